// File: doc/BRIEF.md
# Multi-Mode Signed Integer Divider

This block is a sequential signed divider for a processor execute stage. It takes a two-bit width selector and up to three 32-bit operand words, then produces a quotient and, in some modes, a remainder. It also produces register write strobes, condition flags and a divide-by-zero trap request. Three width modes are provided:
- A half mode divides a 32-bit dividend by a 16-bit divisor and packs the two 16-bit results into one word.
- A single mode divides 32 bits by 32 bits and keeps only the quotient.
- A double mode divides a 64-bit dividend, given as two words, by a 32-bit divisor and yields a separate 32-bit quotient and a 32-bit remainder.

The datapath works on magnitudes and produces one quotient bit per clock with a restoring step. The signs are applied in a final cycle. Two conditions finish without any register write. A zero divisor raises the trap request. A quotient that does not fit the signed width of the selected mode raises the overflow flag. The overflow case is found early when the upper part of the dividend magnitude already reaches the divisor magnitude. Otherwise it is found in the final cycle, which lets exactly the most negative quotient through.

Top module: `sdiv_unit`

## Requirements
- R1: Mode 2'b00 divides signed `dividend_lo` by the signed low 16 bits of `divisor` (bits 31:16 ignored). It writes `quotient` = {remainder[15:0], quotient[15:0]} with `wr_q`=1 and `wr_r`=0, and `remainder` reads 0.
- R2: Mode 2'b01 divides signed `dividend_lo` by signed `divisor`; `dividend_hi` is ignored. It writes the 32-bit quotient with `wr_q`=1 and `wr_r`=0, and `remainder` reads 0. Mode 2'b11 behaves exactly as 2'b01.
- R3: Mode 2'b10 divides the signed 64-bit value {`dividend_hi`,`dividend_lo`} by signed `divisor`. It writes both `quotient` and `remainder` with `wr_q`=`wr_r`=1.
- R4: The quotient truncates toward zero. A nonzero remainder carries the sign of the dividend.
- R5: A zero divisor (the low 16 bits in mode 2'b00) gives `trap_div0`=1 with `done`, no write strobe, and `flag_n`=`flag_z`=`flag_v`=0.
- R6: A quotient outside the signed range of the mode's quotient width (16 bits in mode 2'b00, 32 otherwise) gives `flag_v`=1, no write strobe and `flag_n`=`flag_z`=0. A quotient equal to the most negative value of that width completes normally.
- R7: The most negative dividend divided by -1 is reported as overflow in every mode.
- R8: On a normal completion, `flag_n` is the quotient's sign bit and `flag_z` is set when the quotient is zero. In mode 2'b00 both are taken from the 16-bit quotient only. `flag_v`=0 on a normal completion, and `flag_c` is always 0.
- R9: `start` is taken when `busy` is low, and `busy` is high from the next cycle until `done`. Counting the capturing edge as 1, `done` rises after edge 18 in mode 2'b00 and after edge 34 in the other modes. It rises after edge 2 when the divisor is zero, or when the dividend magnitude above the quotient width is at least the divisor magnitude.
- R10: `done` is a one-cycle pulse. `wr_q`, `wr_r` and `trap_div0` are high only together with `done`. A `start` while `busy` is ignored, and all outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division, taken when busy is low |
| mode | input | 2 | Width mode: 00 half, 01 single, 10 double, 11 as 01 |
| dividend_hi | input | 32 | Upper dividend word (double mode only) |
| dividend_lo | input | 32 | Lower dividend word, or the whole dividend |
| divisor | input | 32 | Divisor (low 16 bits in half mode) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results and flags valid |
| quotient | output | 32 | Quotient, or packed remainder:quotient in half mode |
| remainder | output | 32 | Remainder in double mode, else 0 |
| wr_q | output | 1 | Write the quotient destination |
| wr_r | output | 1 | Write the remainder destination |
| flag_n | output | 1 | Quotient negative |
| flag_z | output | 1 | Quotient zero |
| flag_v | output | 1 | Quotient overflow |
| flag_c | output | 1 | Carry, always 0 |
| trap_div0 | output | 1 | Divide-by-zero trap request |

## Verification
The bench aims at the signed-range edges of each mode:
- A quotient of exactly -32768 or -2^31 must complete. A design that does the final range check without the sign would flag overflow there.
- A quotient of +32768 or +2^31 must overflow. Without the late check, the bench would see a wrapped negative result written.
- Each mode divides the most negative dividend by -1 and expects overflow. This covers both the early path (half and double) and the late path (single). Latency is measured for each case, so a missing or misplaced early check shows up as a wrong cycle count.

Sign combinations check that the remainder follows the dividend and never the quotient. The bench also checks that garbage in the ignored divisor bits, the unused dividend word and a second `start` during a run leave the result unchanged.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic [1:0] {
        MD_HALF   = 2'b00,
        MD_SINGLE = 2'b01,
        MD_DOUBLE = 2'b10,
        MD_ALT    = 2'b11
    } div_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;

endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep
    import sdiv_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    mode,
    input  logic [DW-1:0] dvd_hi,
    input  logic [DW-1:0] dvd_lo,
    input  logic [DW-1:0] dvsr,
    output logic [DW-1:0] rem_init,
    output logic [DW-1:0] quo_init,
    output logic [DW-1:0] dvsr_mag,
    output logic          neg_q,
    output logic          neg_r,
    output logic          div_zero,
    output logic          ovf_early,
    output logic          half_mode
);
    localparam int HW = DW / 2;

    logic [2*DW-1:0] full;
    logic [2*DW-1:0] amag;
    logic [DW-1:0]   sv;
    logic            sneg;

    always_comb begin
        half_mode = (mode == MD_HALF);
        full      = (mode == MD_DOUBLE) ? {dvd_hi, dvd_lo}
                                        : {{DW{dvd_lo[DW-1]}}, dvd_lo};
        sv        = half_mode ? {{HW{dvsr[HW-1]}}, dvsr[HW-1:0]} : dvsr;
        neg_r     = full[2*DW-1];
        sneg      = sv[DW-1];
        amag      = neg_r ? (~full + 1'b1) : full;
        dvsr_mag  = sneg ? (~sv + 1'b1) : sv;
        neg_q     = neg_r ^ sneg;
        div_zero  = (sv == '0);
        if (half_mode) begin
            rem_init = {{HW{1'b0}}, amag[DW-1:HW]};
            quo_init = {amag[HW-1:0], {HW{1'b0}}};
        end else begin
            rem_init = amag[2*DW-1:DW];
            quo_init = amag[DW-1:0];
        end
        ovf_early = !div_zero && (rem_init >= dvsr_mag);
    end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] rem,
    input  logic [DW-1:0] quo,
    input  logic [DW-1:0] dvsr_mag,
    output logic [DW-1:0] rem_nx,
    output logic [DW-1:0] quo_nx
);
    logic [DW:0] trial;
    logic [DW:0] diff;
    logic        fits;

    always_comb begin
        trial  = {rem, quo[DW-1]};
        diff   = trial - {1'b0, dvsr_mag};
        fits   = (trial >= {1'b0, dvsr_mag});
        rem_nx = fits ? diff[DW-1:0] : trial[DW-1:0];
        quo_nx = {quo[DW-2:0], fits};
    end
endmodule

// File: rtl/sdiv_finish.sv
module sdiv_finish
    import sdiv_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    mode,
    input  logic [DW-1:0] quo_mag,
    input  logic [DW-1:0] rem_mag,
    input  logic          neg_q,
    input  logic          neg_r,
    output logic [DW-1:0] quo_out,
    output logic [DW-1:0] rem_out,
    output logic          wr_rem,
    output logic          fl_n,
    output logic          fl_z,
    output logic          ovf_late
);
    localparam int        HW    = DW / 2;
    localparam [DW-1:0]   LIM_H = {{(DW-HW){1'b0}}, 1'b1, {(HW-1){1'b0}}};
    localparam [DW-1:0]   LIM_F = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] qs;
    logic [DW-1:0] rs;
    logic [DW-1:0] lim;
    logic          half;

    always_comb begin
        half     = (mode == MD_HALF);
        qs       = neg_q ? (~quo_mag + 1'b1) : quo_mag;
        rs       = neg_r ? (~rem_mag + 1'b1) : rem_mag;
        lim      = (half ? LIM_H : LIM_F) - {{(DW-1){1'b0}}, ~neg_q};
        ovf_late = (quo_mag > lim);
        if (half) begin
            quo_out = {rs[HW-1:0], qs[HW-1:0]};
            rem_out = '0;
            wr_rem  = 1'b0;
            fl_n    = qs[HW-1];
            fl_z    = (qs[HW-1:0] == '0);
        end else begin
            quo_out = qs;
            rem_out = (mode == MD_DOUBLE) ? rs : '0;
            wr_rem  = (mode == MD_DOUBLE);
            fl_n    = qs[DW-1];
            fl_z    = (qs == '0);
        end
    end
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
    import sdiv_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] dividend_hi,
    input  logic [DW-1:0] dividend_lo,
    input  logic [DW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] quotient,
    output logic [DW-1:0] remainder,
    output logic          wr_q,
    output logic          wr_r,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c,
    output logic          trap_div0
);
    localparam int HW = DW / 2;
    localparam int CW = $clog2(DW);

    typedef struct packed {
        div_state_e    st;
        logic [CW-1:0] cnt;
        logic [1:0]    md;
        logic [DW-1:0] rem;
        logic [DW-1:0] quo;
        logic [DW-1:0] bmag;
        logic          nq;
        logic          nr;
        logic          dz;
        logic          ovf;
        logic          done;
        logic [DW-1:0] q_out;
        logic [DW-1:0] r_out;
        logic          wq;
        logic          wr;
        logic          fn;
        logic          fz;
        logic          fv;
        logic          trap;
    } regs_t;

    regs_t s_d, s_q;

    logic [DW-1:0] p_rem, p_quo, p_bmag;
    logic          p_nq, p_nr, p_dz, p_ovf, p_half;
    logic [DW-1:0] st_rem, st_quo;
    logic [DW-1:0] f_quo, f_rem;
    logic          f_wr, f_n, f_z, f_ovf;

    sdiv_prep #(.DW(DW)) u_prep (
        .mode(mode), .dvd_hi(dividend_hi), .dvd_lo(dividend_lo), .dvsr(divisor),
        .rem_init(p_rem), .quo_init(p_quo), .dvsr_mag(p_bmag),
        .neg_q(p_nq), .neg_r(p_nr), .div_zero(p_dz), .ovf_early(p_ovf),
        .half_mode(p_half)
    );

    sdiv_step #(.DW(DW)) u_step (
        .rem(s_q.rem), .quo(s_q.quo), .dvsr_mag(s_q.bmag),
        .rem_nx(st_rem), .quo_nx(st_quo)
    );

    sdiv_finish #(.DW(DW)) u_fin (
        .mode(s_q.md), .quo_mag(s_q.quo), .rem_mag(s_q.rem),
        .neg_q(s_q.nq), .neg_r(s_q.nr),
        .quo_out(f_quo), .rem_out(f_rem), .wr_rem(f_wr),
        .fl_n(f_n), .fl_z(f_z), .ovf_late(f_ovf)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.wq   = 1'b0;
        s_d.wr   = 1'b0;
        s_d.trap = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.md   = mode;
                    s_d.rem  = p_rem;
                    s_d.quo  = p_quo;
                    s_d.bmag = p_bmag;
                    s_d.nq   = p_nq;
                    s_d.nr   = p_nr;
                    s_d.dz   = p_dz;
                    s_d.ovf  = p_ovf;
                    s_d.cnt  = p_half ? CW'(HW - 1) : CW'(DW - 1);
                    s_d.st   = (p_dz || p_ovf) ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                s_d.rem = st_rem;
                s_d.quo = st_quo;
                s_d.cnt = s_q.cnt - CW'(1);
                if (s_q.cnt == '0) s_d.st = ST_FIN;
            end
            ST_FIN: begin
                s_d.st   = ST_IDLE;
                s_d.done = 1'b1;
                s_d.fn   = 1'b0;
                s_d.fz   = 1'b0;
                s_d.fv   = 1'b0;
                if (s_q.dz) begin
                    s_d.trap = 1'b1;
                end else if (s_q.ovf || f_ovf) begin
                    s_d.fv = 1'b1;
                end else begin
                    s_d.q_out = f_quo;
                    s_d.r_out = f_rem;
                    s_d.wq    = 1'b1;
                    s_d.wr    = f_wr;
                    s_d.fn    = f_n;
                    s_d.fz    = f_z;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign done      = s_q.done;
    assign quotient  = s_q.q_out;
    assign remainder = s_q.r_out;
    assign wr_q      = s_q.wq;
    assign wr_r      = s_q.wr;
    assign flag_n    = s_q.fn;
    assign flag_z    = s_q.fz;
    assign flag_v    = s_q.fv;
    assign flag_c    = 1'b0;
    assign trap_div0 = s_q.trap;

    p_trap_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_div0 |-> (!wr_q && !wr_r && !flag_v && !flag_n && !flag_z));

    p_ovf_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_v) |-> (!wr_q && !wr_r && !flag_n && !flag_z));

    p_pulse_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q || wr_r || trap_div0) |-> done);

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_rem_below_dvsr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RUN) |-> (s_q.rem < s_q.bmag));

    p_wr_r_double_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_r |-> (s_q.md == MD_DOUBLE));
endmodule

// File: tb/sdiv_unit_tb.sv
`timescale 1ns/1ps
module sdiv_unit_tb;

    typedef struct packed {
        logic [1:0]  md;
        logic [31:0] hi;
        logic [31:0] lo;
        logic [31:0] dv;
        logic [31:0] eq;
        logic [31:0] er;
        logic        ewq;
        logic        ewr;
        logic        en;
        logic        ez;
        logic        ev;
        logic        et;
        logic [7:0]  ecyc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    // Fields: md, hi, lo, dv, q, r, wq, wr, n, z, v, trap, cycles, requirement
    localparam vec_t TBL [NV] = '{
        '{2'd0, 32'h0, 32'h00000064, 32'h00000007, 32'h0002000E, 32'h0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd18, 4'd1}, // R1
        '{2'd0, 32'h0, 32'hFFFFFF9C, 32'h00000007, 32'hFFFEFFF2, 32'h0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd18, 4'd4}, // R4
        '{2'd0, 32'h0, 32'h00000064, 32'hABCDFFF9, 32'h0002FFF2, 32'h0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd18, 4'd1}, // R1 upper bits ignored
        '{2'd0, 32'h0, 32'hFFFFFF9C, 32'hFFFFFFF9, 32'hFFFE000E, 32'h0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd18, 4'd4}, // R4
        '{2'd0, 32'h0, 32'h00000005, 32'h00000007, 32'h00050000, 32'h0, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd18, 4'd8}, // R8 zero quotient
        '{2'd0, 32'h0, 32'h00010000, 32'h00000001, 32'h0,        32'h0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd2,  4'd6}, // R6 early
        '{2'd0, 32'h0, 32'hFFFF8000, 32'h00000001, 32'h00008000, 32'h0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd18, 4'd6}, // R6 exact -32768
        '{2'd0, 32'h0, 32'h00008000, 32'h00000001, 32'h0,        32'h0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd18, 4'd6}, // R6 late +32768
        '{2'd0, 32'h0, 32'h80000000, 32'h0000FFFF, 32'h0,        32'h0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd2,  4'd7}, // R7
        '{2'd0, 32'h0, 32'h0000007B, 32'hFFFF0000, 32'h0,        32'h0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'd2,  4'd5}, // R5
        '{2'd1, 32'hDEADBEEF, 32'h000F4240, 32'hFFFFFFFD, 32'hFFFAE9EB, 32'h0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd34, 4'd2}, // R2
        '{2'd1, 32'h0, 32'h80000000, 32'hFFFFFFFF, 32'h0,        32'h0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd34, 4'd7}, // R7 late
        '{2'd1, 32'h0, 32'h80000000, 32'h00000001, 32'h80000000, 32'h0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd34, 4'd6}, // R6 exact
        '{2'd1, 32'h0, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFD, 32'h0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd34, 4'd4}, // R4 trunc
        '{2'd2, 32'h1, 32'h00000000, 32'h00000003, 32'h55555555, 32'h1, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'd34, 4'd3}, // R3
        '{2'd2, 32'hFFFFFFFF, 32'h0, 32'h00000003, 32'hAAAAAAAB, 32'hFFFFFFFF, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd34, 4'd4}, // R4
        '{2'd2, 32'h1, 32'h00000000, 32'hFFFFFFFD, 32'hAAAAAAAB, 32'h1, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd34, 4'd4}, // R4
        '{2'd2, 32'h1, 32'h00000000, 32'h00000001, 32'h0,        32'h0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd2,  4'd6}, // R6 early
        '{2'd2, 32'h80000000, 32'h0, 32'hFFFFFFFF, 32'h0,        32'h0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd2,  4'd7}, // R7
        '{2'd2, 32'hFFFFFFFF, 32'h0, 32'h00000002, 32'h80000000, 32'h0, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd34, 4'd6}, // R6 exact
        '{2'd2, 32'h1, 32'h00000000, 32'h00000002, 32'h0,        32'h0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd34, 4'd6}, // R6 late
        '{2'd2, 32'h5, 32'h00000005, 32'h00000000, 32'h0,        32'h0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'd2,  4'd5}, // R5
        '{2'd1, 32'h0, 32'h00000000, 32'h00000005, 32'h0,        32'h0, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd34, 4'd8}, // R8
        '{2'd3, 32'h0, 32'h00000064, 32'h00000007, 32'h0000000E, 32'h0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd34, 4'd2}, // R2 alt mode
        '{2'd1, 32'h0, 32'h00000005, 32'h00000000, 32'h0,        32'h0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'd2,  4'd5}  // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [31:0] dividend_hi = '0, dividend_lo = '0, divisor = '0;
    logic        busy, done, wr_q, wr_r, flag_n, flag_z, flag_v, flag_c, trap_div0;
    logic [31:0] quotient, remainder;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    sdiv_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .dividend_hi(dividend_hi), .dividend_lo(dividend_lo), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
        .wr_q(wr_q), .wr_r(wr_r), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .trap_div0(trap_div0)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] md, input logic [31:0] hi,
                         input logic [31:0] lo, input logic [31:0] dv);
        @(negedge clk);
        mode = md; dividend_hi = hi; dividend_lo = lo; divisor = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R9 watchdog act=%0d exp=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10", "reset busy", {31'b0, busy}, 32'd0);
        chk("R10", "reset done", {31'b0, done}, 32'd0);
        chk("R10", "reset strobes", {29'b0, wr_q, wr_r, trap_div0}, 32'd0);
        chk("R8", "reset flags", {28'b0, flag_n, flag_z, flag_v, flag_c}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d", TBL[i].req);
            issue(TBL[i].md, TBL[i].hi, TBL[i].lo, TBL[i].dv);
            chk("R9", $sformatf("v%0d busy", i), {31'b0, busy}, 32'd1);
            wait_done(cyc);
            chk("R9", $sformatf("v%0d latency", i), cyc, {24'b0, TBL[i].ecyc});
            chk(tg, $sformatf("v%0d wr_q", i), {31'b0, wr_q}, {31'b0, TBL[i].ewq});
            chk(tg, $sformatf("v%0d wr_r", i), {31'b0, wr_r}, {31'b0, TBL[i].ewr});
            chk(tg, $sformatf("v%0d trap", i), {31'b0, trap_div0}, {31'b0, TBL[i].et});
            chk(tg, $sformatf("v%0d flag_v", i), {31'b0, flag_v}, {31'b0, TBL[i].ev});
            chk("R8", $sformatf("v%0d flag_n", i), {31'b0, flag_n}, {31'b0, TBL[i].en});
            chk("R8", $sformatf("v%0d flag_z", i), {31'b0, flag_z}, {31'b0, TBL[i].ez});
            chk("R8", $sformatf("v%0d flag_c", i), {31'b0, flag_c}, 32'd0);
            if (TBL[i].ewq) begin
                chk(tg, $sformatf("v%0d quotient", i), quotient, TBL[i].eq);
                chk(tg, $sformatf("v%0d remainder", i), remainder, TBL[i].er);
            end
            @(negedge clk);
            chk("R10", $sformatf("v%0d pulse end", i),
                {28'b0, done, wr_q, wr_r, trap_div0}, 32'd0);
            chk("R9", $sformatf("v%0d idle", i), {31'b0, busy}, 32'd0);
        end

        // R10: start while busy is ignored (second request is a zero divide)
        issue(2'd1, 32'h0, 32'h00000064, 32'h00000007);
        cyc = 1;
        repeat (4) begin @(negedge clk); cyc++; end
        mode = 2'd0; dividend_lo = 32'h7B; divisor = 32'h0; start = 1'b1;
        @(negedge clk); cyc++;
        start = 1'b0;
        while (!done && cyc < 200) begin @(negedge clk); cyc++; end
        chk("R10", "ignored start latency", cyc, 32'd34);
        chk("R10", "ignored start quotient", quotient, 32'h0000000E);
        chk("R10", "ignored start trap", {31'b0, trap_div0}, 32'd0);
        chk("R10", "ignored start wr_q", {31'b0, wr_q}, 32'd1);

        // R9: reset in the middle of a run returns to idle
        issue(2'd2, 32'h1, 32'h0, 32'h3);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "reset mid-run busy", {31'b0, busy}, 32'd0);
        chk("R10", "reset mid-run done", {31'b0, done}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule